// File: doc/BRIEF.md
# Lockstep Serial-Shifter TAP Master

This block drives a JTAG test access port with two serial shift engines that share one shift clock. That shared clock leaves the block as TCK. The first engine's serial output is TMS, so each shifted bit moves the TAP state machine one step. The second engine's serial output is TDI, and the same engine captures TDO. The two engines run off the same clock strobes, so every state step and every data bit fall on the same TCK cycle.

A host loads a TMS word and a TDI word of up to 32 bits, sets a bit count and an even clock divisor, and pulses `start`. The block emits exactly that many TCK cycles and returns the captured TDO bits in a parallel word. It then raises `done` for one cycle. A separate register sets the optional active-low TAP reset line.

Top module: `dual_spi_jtag_bridge`

## Requirements
- R1: After synchronous reset, `tck`, `tms`, `tdi`, `busy`, `done` and `tdo_word` are all 0, and `trst_n` is 1.
- R2: When idle, `tck` is low. A transfer of N bits produces exactly N rising and N falling edges of `tck`, and `tck` ends low.
- R3: Each high phase and each low phase of `tck` lasts `clk_div`/2 system clocks. The phase before the first rising edge counts as a low phase. An odd divisor is rounded down, and a divisor below 2 acts as 2.
- R4: `tms` presents `tms_word` LSB first. Bit 0 is present from the cycle after `start` is accepted. Bit k is present at the k-th rising edge of `tck` (counted from 0), and bits change only on falling edges of `tck`.
- R5: `tdi` presents `tdi_word` LSB first and advances on the same falling edges as `tms`, so bit k of both words is present at the same rising edge.
- R6: `tdo` is sampled at the k-th rising edge of `tck` into bit k of `tdo_word`. Bits at index N and above read 0.
- R7: `busy` is 1 from the cycle after `start` is accepted until the last falling edge of `tck`. `done` is a single-cycle pulse in the cycle after that edge, when `busy` is already 0.
- R8: A `start` pulse while `busy` is 1 is ignored. It does not change the running transfer, and no second transfer follows.
- R9: A `bit_count` of 0 runs a 1-bit transfer. A `bit_count` above 32 runs a 32-bit transfer.
- R10: When `trst_we` is 1 at a clock edge, `trst_n` takes `trst_val` from the next cycle on. Otherwise `trst_n` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| bit_count | input | 6 | Number of TCK cycles, 1 to 32 |
| clk_div | input | 8 | System clocks per TCK period (even, at least 2) |
| tms_word | input | 32 | TMS bits, LSB sent first |
| tdi_word | input | 32 | TDI bits, LSB sent first |
| trst_we | input | 1 | Write strobe for the reset register |
| trst_val | input | 1 | Value written to the reset register |
| tdo | input | 1 | Serial data from the TAP |
| tck | output | 1 | Shared shift clock, used as the TAP clock |
| tms | output | 1 | Serial output of the first shift engine |
| tdi | output | 1 | Serial output of the second shift engine |
| trst_n | output | 1 | Active-low TAP reset from the register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| tdo_word | output | 32 | Captured TDO bits |

## Verification
The bench keeps the package defaults: 32-bit words and an 8-bit divisor field. It drives divisors of 0, 2, 4, 6, 7 and 10, which covers the fastest TCK, the rounding of an odd divisor and the floor applied below 2, with every TCK phase timed. Bit counts of 0, 1, 5, 8, 13, 32 and 40 exercise both clamps and the full-width word. A target model in the bench changes TDO after each rising edge, so a capture on the wrong edge or into the wrong bit position shows up as a wrong bit in the returned word.

// File: rtl/jtag_br_pkg.sv
package jtag_br_pkg;

    // Geometry of one transfer
    localparam int MAX_BITS = 32;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int IDX_W    = $clog2(MAX_BITS);
    localparam int DIV_W    = 8;
    localparam int HALF_W   = DIV_W - 1;
    localparam int LANES    = 2;
    localparam int TMS_LANE = 0;
    localparam int TDI_LANE = 1;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_state_t;

    // Settings latched when a transfer is accepted
    typedef struct packed {
        logic [IDX_W-1:0]  last_idx;
        logic [HALF_W-1:0] half;
    } xfer_cfg_t;

    // Clamp the requested count to 1..MAX_BITS and return the final index
    function automatic logic [IDX_W-1:0] last_index(input logic [CNT_W-1:0] n);
        if (n == '0)
            return '0;
        else if (int'(n) > MAX_BITS)
            return IDX_W'(MAX_BITS - 1);
        else
            return IDX_W'(n - 1'b1);
    endfunction

    // Half period in system clocks; divisors below 2 act as 2
    function automatic logic [HALF_W-1:0] half_of(input logic [DIV_W-1:0] div);
        logic [HALF_W-1:0] h;
        h = div[DIV_W-1:1];
        if (h == '0)
            h = HALF_W'(1);
        return h;
    endfunction

endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen
    import jtag_br_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [HW-1:0] half,
    output logic          tck,
    output logic          rise_now,
    output logic          fall_now
);

    logic [HW-1:0] hc;
    logic          wrap;

    assign wrap     = run && (hc == half - 1'b1);
    assign rise_now = wrap && !tck;
    assign fall_now = wrap && tck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc  <= '0;
            tck <= 1'b0;
        end else if (wrap) begin
            hc  <= '0;
            tck <= ~tck;
        end else begin
            hc  <= hc + 1'b1;
        end
    end

    // R3
    hc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (hc < half));

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !tck);

endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
    import jtag_br_pkg::*;
#(
    parameter int W       = MAX_BITS,
    parameter int IW      = IDX_W,
    parameter bit CAPTURE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  load_word,
    input  logic          advance,
    input  logic          capture,
    input  logic [IW-1:0] cap_idx,
    input  logic          sdi,
    output logic          sdo,
    output logic [W-1:0]  rx_word
);

    logic [W-1:0] tx;

    always_ff @(posedge clk) begin
        if (rst)
            tx <= '0;
        else if (load)
            tx <= load_word;
        else if (advance)
            tx <= tx >> 1;
    end

    assign sdo = tx[0];

    generate
        if (CAPTURE) begin : g_rx
            logic [W-1:0] rx;
            always_ff @(posedge clk) begin
                if (rst || load)
                    rx <= '0;
                else if (capture)
                    rx[cap_idx] <= sdi;
            end
            assign rx_word = rx;
        end else begin : g_no_rx
            assign rx_word = '0;
        end
    endgenerate

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(advance)) |-> $stable(sdo));

endmodule

// File: rtl/dual_spi_jtag_bridge.sv
module dual_spi_jtag_bridge
    import jtag_br_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [CNT_W-1:0]    bit_count,
    input  logic [DIV_W-1:0]    clk_div,
    input  logic [MAX_BITS-1:0] tms_word,
    input  logic [MAX_BITS-1:0] tdi_word,
    input  logic                trst_we,
    input  logic                trst_val,
    input  logic                tdo,
    output logic                tck,
    output logic                tms,
    output logic                tdi,
    output logic                trst_n,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] tdo_word
);

    seq_state_t       state;
    xfer_cfg_t        cfg;
    logic [IDX_W-1:0] idx;
    logic             accept, rise_now, fall_now, last_fall;
    logic             trst_q;

    assign accept    = start && (state == SEQ_IDLE);
    assign busy      = (state == SEQ_SHIFT);
    assign last_fall = fall_now && (idx == cfg.last_idx);

    // Sequencer: counts falling edges and ends the transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cfg   <= '0;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: if (start) begin
                    cfg.last_idx <= last_index(bit_count);
                    cfg.half     <= half_of(clk_div);
                    idx          <= '0;
                    state        <= SEQ_SHIFT;
                end
                SEQ_SHIFT: if (fall_now) begin
                    if (idx == cfg.last_idx) begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    jtag_tck_gen #(.HW(HALF_W)) u_tck (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .half     (cfg.half),
        .tck      (tck),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    // Two shift engines on the same clock strobes
    logic [MAX_BITS-1:0] lane_load [LANES];
    logic [MAX_BITS-1:0] lane_rx   [LANES];
    logic                lane_sdo  [LANES];
    logic                lane_sdi  [LANES];

    assign lane_load[TMS_LANE] = tms_word;
    assign lane_load[TDI_LANE] = tdi_word;
    assign lane_sdi[TMS_LANE]  = 1'b0;
    assign lane_sdi[TDI_LANE]  = tdo;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            jtag_shift_engine #(
                .W       (MAX_BITS),
                .IW      (IDX_W),
                .CAPTURE (g == TDI_LANE)
            ) u_eng (
                .clk       (clk),
                .rst       (rst),
                .load      (accept),
                .load_word (lane_load[g]),
                .advance   (fall_now && !last_fall),
                .capture   (rise_now),
                .cap_idx   (idx),
                .sdi       (lane_sdi[g]),
                .sdo       (lane_sdo[g]),
                .rx_word   (lane_rx[g])
            );
        end
    endgenerate

    assign tms      = lane_sdo[TMS_LANE];
    assign tdi      = lane_sdo[TDI_LANE];
    // Only the capturing lane contributes non-zero bits
    assign tdo_word = lane_rx[TMS_LANE] | lane_rx[TDI_LANE];

    // Reset register for the TAP
    always_ff @(posedge clk) begin
        if (rst)
            trst_q <= 1'b1;
        else if (trst_we)
            trst_q <= trst_val;
    end
    assign trst_n = trst_q;

    // R2
    tck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $fell(busy)));

    // R5
    lockstep_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !$fell(tck)) |-> ($stable(tms) && $stable(tdi)));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> $stable(cfg));

    // R10
    trst_write_chk: assert property (@(posedge clk) disable iff (rst)
        $past(trst_we) |-> (trst_n == $past(trst_val)));

endmodule

// File: tb/dual_spi_jtag_bridge_test.sv
module dual_spi_jtag_bridge_test;
    import jtag_br_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [CNT_W-1:0]    bit_count = '0;
    logic [DIV_W-1:0]    clk_div = '0;
    logic [MAX_BITS-1:0] tms_word = '0;
    logic [MAX_BITS-1:0] tdi_word = '0;
    logic                trst_we = 1'b0;
    logic                trst_val = 1'b0;
    logic                tdo;
    logic                tck, tms, tdi, trst_n, busy, done;
    logic [MAX_BITS-1:0] tdo_word;

    always #4 clk = ~clk;

    dual_spi_jtag_bridge uut (
        .clk(clk), .rst(rst), .start(start), .bit_count(bit_count),
        .clk_div(clk_div), .tms_word(tms_word), .tdi_word(tdi_word),
        .trst_we(trst_we), .trst_val(trst_val), .tdo(tdo),
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
        .busy(busy), .done(done), .tdo_word(tdo_word)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Target model: TDO moves to the next pattern bit after each rising TCK
    logic [31:0] tdo_pat = '0;
    int          rise_k  = 0;
    assign tdo = (rise_k < 32) ? tdo_pat[rise_k] : 1'b0;
    always @(posedge tck) rise_k <= rise_k + 1;

    typedef struct {
        int          n;
        int          half;
        logic [31:0] tms;
        logic [31:0] tdi;
        logic [31:0] tdo;
    } exp_t;
    exp_t q[$];

    function automatic logic [31:0] mask_of(input int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return m[31:0];
    endfunction

    // Monitor: measures TCK phases, records TMS/TDI at rises, scores on done
    logic        prev_tck = 1'b0, prev_busy = 1'b0;
    int          run_len = 0, rises = 0, per_err = 0;
    logic [31:0] tms_seen = '0, tdi_seen = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !prev_busy) begin
                run_len = 1; rises = 0; per_err = 0;
                tms_seen = '0; tdi_seen = '0;
            end else if (busy || prev_busy) begin
                if (tck != prev_tck) begin
                    if (q.size() > 0 && run_len != q[0].half) per_err++;
                    run_len = 1;
                    if (tck) begin
                        if (rises < 32) begin
                            tms_seen[rises] = tms;
                            tdi_seen[rises] = tdi;
                        end
                        rises++;
                    end
                end else begin
                    run_len++;
                end
            end
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(rises == e.n, "R2/R9", "rising edge count", rises, e.n);
                    chk(per_err == 0, "R3", "tck phase length errors", per_err, 0);
                    chk(tms_seen == (e.tms & mask_of(e.n)), "R4", "tms bits",
                        tms_seen, e.tms & mask_of(e.n));
                    chk(tdi_seen == (e.tdi & mask_of(e.n)), "R5", "tdi bits",
                        tdi_seen, e.tdi & mask_of(e.n));
                    chk(tdo_word == (e.tdo & mask_of(e.n)), "R6", "tdo_word",
                        tdo_word, e.tdo & mask_of(e.n));
                    chk(!busy && !tck, "R7", "busy/tck at done", {busy, tck}, 0);
                end
            end
        end
        prev_tck  = tck;
        prev_busy = busy;
    end

    // Driver: pushes the expected item, then launches the transfer
    task automatic xfer(input int n_in, input int div_in, input logic [31:0] tm,
                        input logic [31:0] ti, input logic [31:0] to,
                        input bit poke_busy);
        exp_t e;
        e.n    = (n_in == 0) ? 1 : (n_in > 32 ? 32 : n_in);
        e.half = (div_in < 2) ? 1 : (div_in >> 1);
        e.tms  = tm; e.tdi = ti; e.tdo = to;
        q.push_back(e);
        tdo_pat = to;
        rise_k  = 0;
        @(negedge clk);
        start = 1'b1; bit_count = CNT_W'(n_in); clk_div = DIV_W'(div_in);
        tms_word = tm; tdi_word = ti;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R7", "busy after start", {busy, done}, 2'b10);
        chk(tms == tm[0] && tdi == ti[0], "R4", "bit 0 present before first rise",
            {tms, tdi}, {tm[0], ti[0]});
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            // R8: start while busy with different settings
            start = 1'b1; bit_count = 6'd3; clk_div = 8'd2;
            tms_word = ~tm; tdi_word = ~ti;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!tck && !tms && !tdi && !busy && !done, "R1", "outputs after reset",
            {tck, tms, tdi, busy, done}, 0);
        chk(tdo_word == 0 && trst_n, "R1", "tdo_word/trst_n after reset",
            {tdo_word[30:0], trst_n}, 1);

        xfer(1, 2, 32'h1, 32'h0, 32'h1, 1'b0);
        xfer(8, 4, 32'h0000_00B5, 32'h0000_003C, 32'h0000_00A6, 1'b0);
        xfer(32, 2, 32'hDEAD_BEEF, 32'h1234_5678, 32'hC3A5_0F96, 1'b0);
        xfer(5, 7, 32'h0000_0013, 32'h0000_000A, 32'hFFFF_FFFF, 1'b0);  // R3 odd
        xfer(0, 0, 32'h1, 32'h1, 32'h0, 1'b0);                          // R9 R3 floor
        xfer(40, 6, 32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'h8000_0001, 1'b0); // R9 clamp
        xfer(13, 10, 32'h0000_1ABC, 32'h0000_0F0F, 32'h0000_1555, 1'b1); // R8

        // R8: no second transfer follows the ignored start
        repeat (20) @(negedge clk);
        chk(!busy && !tck && q.size() == 0, "R8", "idle after ignored start",
            {busy, tck}, 0);

        // R10
        trst_we = 1'b1; trst_val = 1'b0;
        @(negedge clk);
        trst_we = 1'b0; trst_val = 1'b1;
        chk(trst_n == 1'b0, "R10", "trst_n written low", trst_n, 0);
        @(negedge clk);
        chk(trst_n == 1'b0, "R10", "trst_n holds without write", trst_n, 0);
        trst_we = 1'b1;
        @(negedge clk);
        trst_we = 1'b0;
        chk(trst_n == 1'b1, "R10", "trst_n written high", trst_n, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule